// File: doc/BRIEF.md
# Audio Master and Bit Clock Generator

This block produces the clocks that one audio serial port needs when it acts as clock master. Every flop runs on a single kernel audio clock. From that clock the block derives three outputs: a master clock for external codecs, a bit clock for the serial shifter, and a one-cycle frame-rate strobe. A 4-bit divider code sets the master clock. Code zero passes the kernel clock straight through. Any other code N divides the kernel clock by 2N, which always gives a 50% duty cycle.

The bit clock runs at a fixed ratio to the master clock and changes state only on master-clock rising edges. The frame strobe fires once every 256 master-clock periods. The master clock reaches the pin only when the port is master, the time-division-multiplexed protocol is selected and the no-divide override is clear. The master/slave select, the protocol select, the override and the divider code are taken in only while the enable is low. While the enable is low, every counter restarts and every output rests at 0. As a slave the block generates nothing.

Top module: `audio_clkgen`

## Requirements
- R1: With a nonzero divider code N, the master clock has a period of 2N kernel clock cycles and is high for exactly N of them.
- R2: With divider code 0, the master clock is a gated copy of the kernel clock: same period, high while the kernel clock is high.
- R3: The bit clock has a period of 4 master-clock periods and is high for 2 of them, in both divided and pass-through settings.
- R4: The frame strobe is high for exactly one kernel cycle, once every 256 master-clock periods (256·2N kernel cycles for code N, 256 for code 0).
- R5: In slave mode (master select = 0) the master clock, the bit clock and the frame strobe all stay at 0 while enabled.
- R6: With the no-divide flag = 1, the master clock stays at 0, while the bit clock and frame strobe keep running.
- R7: With the protocol select = 0 (not TDM), the master clock stays at 0, while the bit clock keeps running.
- R8: The divider code, master select, protocol select and no-divide flag are sampled only while the enable is low. Changes made while the enable is high have no effect until the enable is dropped.
- R9: While the enable is low, all three outputs are 0 and all counters restart. After re-enabling, the clocks resume with the configured periods.
- R10: Synchronous active-high reset drives all three outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_k | input | 1 | Kernel audio clock |
| rst | input | 1 | Synchronous active-high reset |
| master_sel | input | 1 | 1 = clock master, 0 = slave (generation off) |
| run_en | input | 1 | Enable; configuration is captured while low |
| div_code | input | 4 | Master-clock divider code (0 = pass-through, N = divide by 2N) |
| nodiv | input | 1 | 1 = hold the master clock output at 0 |
| tdm_sel | input | 1 | 1 = TDM protocol (master clock driven), 0 = other protocol |
| mclk_o | output | 1 | Master clock to external codecs |
| bclk_o | output | 1 | Bit clock |
| fs_pulse | output | 1 | One-kernel-cycle frame-rate strobe |

## Verification
The bench measures the master clock's period and high time for codes 1, 2, 15 and 0. A divider that wraps one count late or early would show a wrong period. A path that toggled on both phases would break the duty cycle, and a pass-through path that was not gated would still show a clock while the block is idle. A scoreboard compares the intervals between frame strobes against 256 master periods, so a frame counter that is off by one, or a strobe wider than one cycle, is reported. The bench rewrites the divider code while the block is enabled and expects the period to stay the same, which exposes a design that reloads its configuration at the wrong time. Slave mode, the no-divide override and non-TDM operation are each watched in the kernel clock's high phase, where a leak through the pass-through gate would be seen.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

    // Width of the master-clock divider code.
    localparam int DIV_CODE_W = 4;
    // Master-clock periods per frame strobe.
    localparam int MCLK_PER_FRAME = 256;
    // Master-clock periods per bit-clock period (must be even).
    localparam int MCLK_PER_BCLK = 4;

    typedef logic [DIV_CODE_W-1:0] div_code_t;

    typedef struct packed {
        logic      master;
        logic      tdm;
        logic      nodiv;
        div_code_t code;
    } clk_cfg_t;

    localparam clk_cfg_t CFG_IDLE = '{master: 1'b0, tdm: 1'b0, nodiv: 1'b0, code: '0};

    function automatic logic code_is_bypass(input div_code_t c);
        return (c == '0);
    endfunction

    function automatic logic mclk_allowed(input clk_cfg_t c);
        return c.master && c.tdm && !c.nodiv;
    endfunction

endpackage

// File: rtl/aclk_cfg_hold.sv
module aclk_cfg_hold
    import aclk_pkg::*;
(
    input  logic     clk_k,
    input  logic     rst,
    input  logic     run_en,
    input  clk_cfg_t cfg_in,
    output clk_cfg_t cfg_q
);

    // Configuration follows its inputs only while the generator is idle.
    always_ff @(posedge clk_k) begin
        if (rst) begin
            cfg_q <= CFG_IDLE;
        end else if (!run_en) begin
            cfg_q <= cfg_in;
        end
    end

endmodule

// File: rtl/aclk_mclk_div.sv
module aclk_mclk_div
    import aclk_pkg::*;
#(
    parameter int CODE_W = DIV_CODE_W
) (
    input  logic              clk_k,
    input  logic              rst,
    input  logic              active,
    input  logic [CODE_W-1:0] code,
    output logic              tgl_o,
    output logic              tick_o
);

    logic [CODE_W-1:0] cnt_q;
    logic              tgl_q;
    logic              bypass;
    logic              wrap;

    assign bypass = (code == '0);
    assign wrap   = (cnt_q == code - CODE_W'(1));

    always_ff @(posedge clk_k) begin
        if (rst || !active) begin
            cnt_q <= '0;
            tgl_q <= 1'b0;
        end else if (bypass) begin
            cnt_q <= '0;
            tgl_q <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            tgl_q <= ~tgl_q;
        end else begin
            cnt_q <= cnt_q + CODE_W'(1);
        end
    end

    // A tick marks the kernel edge on which the master clock rises.
    assign tick_o = active && (bypass || (wrap && !tgl_q));
    assign tgl_o  = tgl_q;

endmodule

// File: rtl/aclk_rate_div.sv
module aclk_rate_div #(
    parameter int PER_BCLK  = 4,
    parameter int PER_FRAME = 256
) (
    input  logic clk_k,
    input  logic rst,
    input  logic active,
    input  logic tick,
    output logic bclk_o,
    output logic stb_o
);

    localparam int HALF    = PER_BCLK / 2;
    localparam int FCNT_W  = $clog2(PER_FRAME);

    logic              bclk_q;
    logic              stb_q;
    logic [FCNT_W-1:0] fcnt_q;
    logic              frame_end;

    generate
        if (HALF == 1) begin : g_bclk_direct
            always_ff @(posedge clk_k) begin
                if (rst || !active) begin
                    bclk_q <= 1'b0;
                end else if (tick) begin
                    bclk_q <= ~bclk_q;
                end
            end
        end else begin : g_bclk_count
            localparam int HCNT_W = $clog2(HALF);
            logic [HCNT_W-1:0] hcnt_q;
            always_ff @(posedge clk_k) begin
                if (rst || !active) begin
                    hcnt_q <= '0;
                    bclk_q <= 1'b0;
                end else if (tick) begin
                    if (hcnt_q == HCNT_W'(HALF - 1)) begin
                        hcnt_q <= '0;
                        bclk_q <= ~bclk_q;
                    end else begin
                        hcnt_q <= hcnt_q + HCNT_W'(1);
                    end
                end
            end
        end
    endgenerate

    assign frame_end = (fcnt_q == FCNT_W'(PER_FRAME - 1));

    always_ff @(posedge clk_k) begin
        if (rst || !active) begin
            fcnt_q <= '0;
            stb_q  <= 1'b0;
        end else begin
            stb_q <= tick && frame_end;
            if (tick) begin
                fcnt_q <= frame_end ? '0 : fcnt_q + FCNT_W'(1);
            end
        end
    end

    assign bclk_o = bclk_q;
    assign stb_o  = stb_q;

endmodule

// File: rtl/aclk_out_gate.sv
module aclk_out_gate
    import aclk_pkg::*;
(
    input  logic     clk_k,
    input  logic     rst,
    input  logic     active,
    input  clk_cfg_t cfg,
    input  logic     tgl,
    output logic     mclk_o
);

    logic allow;
    logic gate_n;

    assign allow = active && mclk_allowed(cfg);

    // Gate for the pass-through path changes while the kernel clock is low,
    // so the gated copy never carries a truncated high phase.
    always_ff @(negedge clk_k) begin
        if (rst) begin
            gate_n <= 1'b0;
        end else begin
            gate_n <= allow && code_is_bypass(cfg.code);
        end
    end

    always_comb begin
        if (code_is_bypass(cfg.code)) begin
            mclk_o = clk_k & gate_n;
        end else begin
            mclk_o = tgl & allow;
        end
    end

endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
    import aclk_pkg::*;
#(
    parameter int PER_BCLK  = MCLK_PER_BCLK,
    parameter int PER_FRAME = MCLK_PER_FRAME
) (
    input  logic                  clk_k,
    input  logic                  rst,
    input  logic                  master_sel,
    input  logic                  run_en,
    input  logic [DIV_CODE_W-1:0] div_code,
    input  logic                  nodiv,
    input  logic                  tdm_sel,
    output logic                  mclk_o,
    output logic                  bclk_o,
    output logic                  fs_pulse
);

    clk_cfg_t cfg_in;
    clk_cfg_t cfg_q;
    logic     active;
    logic     tgl;
    logic     tick;

    assign cfg_in = '{master: master_sel, tdm: tdm_sel, nodiv: nodiv, code: div_code};
    assign active = run_en && cfg_q.master;

    aclk_cfg_hold u_cfg (
        .clk_k  (clk_k),
        .rst    (rst),
        .run_en (run_en),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    aclk_mclk_div #(.CODE_W(DIV_CODE_W)) u_div (
        .clk_k  (clk_k),
        .rst    (rst),
        .active (active),
        .code   (cfg_q.code),
        .tgl_o  (tgl),
        .tick_o (tick)
    );

    aclk_rate_div #(.PER_BCLK(PER_BCLK), .PER_FRAME(PER_FRAME)) u_rate (
        .clk_k  (clk_k),
        .rst    (rst),
        .active (active),
        .tick   (tick),
        .bclk_o (bclk_o),
        .stb_o  (fs_pulse)
    );

    aclk_out_gate u_gate (
        .clk_k  (clk_k),
        .rst    (rst),
        .active (active),
        .cfg    (cfg_q),
        .tgl    (tgl),
        .mclk_o (mclk_o)
    );

endmodule

// File: rtl/audio_clkgen_chk.sv
module audio_clkgen_chk
    import aclk_pkg::*;
(
    input logic     clk_k,
    input logic     rst,
    input logic     master_sel,
    input logic     run_en,
    input logic     mclk_o,
    input logic     bclk_o,
    input logic     fs_pulse,
    input clk_cfg_t cfg_q
);

    // R4: frame strobe lasts a single kernel cycle
    a_r4_single_strobe: assert property (@(posedge clk_k) disable iff (rst)
        fs_pulse |=> !fs_pulse);

    // R9: idle generator drives quiet outputs on the following cycle
    a_r9_idle_quiet: assert property (@(posedge clk_k) disable iff (rst)
        !run_en |=> (!bclk_o && !fs_pulse));

    // R5: slave configuration leaves bit clock and strobe low
    a_r5_slave_quiet: assert property (@(posedge clk_k) disable iff (rst)
        (!run_en && !master_sel) |=> (!bclk_o && !fs_pulse));

    // R6: no-divide override keeps the master clock low (checked in the high phase)
    a_r6_nodiv_low: assert property (@(negedge clk_k) disable iff (rst)
        (run_en && cfg_q.nodiv) |-> !mclk_o);

    // R7: non-TDM protocol keeps the master clock low (checked in the high phase)
    a_r7_non_tdm_low: assert property (@(negedge clk_k) disable iff (rst)
        (run_en && !cfg_q.tdm) |-> !mclk_o);

    // R8: configuration is frozen while enabled
    a_r8_cfg_frozen: assert property (@(posedge clk_k) disable iff (rst)
        (run_en && $past(run_en) && !$past(rst)) |-> $stable(cfg_q));

endmodule

bind audio_clkgen audio_clkgen_chk u_chk (
    .clk_k      (clk_k),
    .rst        (rst),
    .master_sel (master_sel),
    .run_en     (run_en),
    .mclk_o     (mclk_o),
    .bclk_o     (bclk_o),
    .fs_pulse   (fs_pulse),
    .cfg_q      (cfg_q)
);

// File: tb/audio_clkgen_tb.sv
module audio_clkgen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_P     = CLK_PERIOD / 2;
    localparam int QTR_P      = CLK_PERIOD / 4;

    logic       clk_k = 1'b0;
    logic       rst = 1'b1;
    logic       master_sel = 1'b0;
    logic       run_en = 1'b0;
    logic [3:0] div_code = 4'd0;
    logic       nodiv = 1'b0;
    logic       tdm_sel = 1'b0;
    logic       mclk_o;
    logic       bclk_o;
    logic       fs_pulse;

    int total = 0;
    int bad = 0;

    // Scoreboard of expected frame-strobe intervals (kernel cycles).
    int  exp_q[$];
    bit  have_last = 0;
    int  last_cyc = 0;
    int  cyc = 0;
    bit  prev_stb = 0;

    always #(HALF_P) clk_k = ~clk_k;

    audio_clkgen u_dut (
        .clk_k      (clk_k),
        .rst        (rst),
        .master_sel (master_sel),
        .run_en     (run_en),
        .div_code   (div_code),
        .nodiv      (nodiv),
        .tdm_sel    (tdm_sel),
        .mclk_o     (mclk_o),
        .bclk_o     (bclk_o),
        .fs_pulse   (fs_pulse)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: pops expected strobe intervals and checks pulse width.
    always @(negedge clk_k) begin
        cyc++;
        if (fs_pulse && prev_stb) chk(0, "R4 strobe width", 2, 1);
        if (fs_pulse) begin
            if (have_last && exp_q.size() > 0) begin
                chk((cyc - last_cyc) == exp_q[0], "R4 frame interval", cyc - last_cyc, exp_q[0]);
                void'(exp_q.pop_front());
            end
            have_last = 1;
            last_cyc  = cyc;
        end
        prev_stb = fs_pulse;
    end

    task automatic configure(input bit m, input bit t, input bit nd, input logic [3:0] c);
        @(negedge clk_k);
        run_en = 1'b0;
        master_sel = m; tdm_sel = t; nodiv = nd; div_code = c;
        repeat (3) @(negedge clk_k);
        have_last = 0;
        run_en = 1'b1;
        repeat (2) @(negedge clk_k);
    endtask

    // Driver side of the scoreboard: push expected intervals and wait for them.
    task automatic expect_frames(input int n, input int interval);
        for (int i = 0; i < n; i++) exp_q.push_back(interval);
        while (exp_q.size() > 0) @(negedge clk_k);
    endtask

    task automatic meas(input bit which_b, input longint exp_per, input longint exp_hi, input string tag);
        longint t0, t1, t2;
        if (which_b) begin
            @(posedge bclk_o); t0 = $time;
            @(negedge bclk_o); t1 = $time;
            @(posedge bclk_o); t2 = $time;
        end else begin
            @(posedge mclk_o); t0 = $time;
            @(negedge mclk_o); t1 = $time;
            @(posedge mclk_o); t2 = $time;
        end
        chk((t2 - t0) == exp_per, {tag, " period"}, t2 - t0, exp_per);
        chk((t1 - t0) == exp_hi, {tag, " high time"}, t1 - t0, exp_hi);
    endtask

    // Watch outputs in the kernel clock's high phase for n cycles.
    task automatic watch_low(input int n, input bit want_m, input bit want_b, input string tag);
        int mh = 0, bh = 0, sh = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk_k); #(QTR_P);
            if (mclk_o) mh++;
            if (bclk_o) bh++;
            if (fs_pulse) sh++;
        end
        if (want_m) chk(mh == 0, {tag, " mclk high samples"}, mh, 0);
        if (want_b) chk(bh == 0 && sh == 0, {tag, " bclk/strobe high samples"}, bh + sh, 0);
    endtask

    task automatic run_code(input logic [3:0] c, input int nframes);
        longint per = (c == 0) ? CLK_PERIOD : 2 * CLK_PERIOD * c;
        int fint = (c == 0) ? 256 : 256 * 2 * c;
        configure(1, 1, 0, c);
        if (c == 0) meas(0, per, per / 2, "R2 pass-through mclk");
        else        meas(0, per, per / 2, "R1 divided mclk");
        meas(1, 4 * per, 2 * per, "R3 bclk");
        expect_frames(nframes, fint);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        chk(0, "watchdog", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk_k);
        // R10: reset state
        @(posedge clk_k); #(QTR_P);
        chk(!mclk_o && !bclk_o && !fs_pulse, "R10 reset outputs", {mclk_o, bclk_o, fs_pulse}, 0);
        @(negedge clk_k);
        rst = 1'b0;
        watch_low(10, 1, 1, "R9 idle after reset");

        run_code(4'd1, 2);
        run_code(4'd2, 2);
        run_code(4'd15, 1);
        run_code(4'd0, 2);

        // R8: code change while enabled is ignored
        configure(1, 1, 0, 4'd1);
        @(negedge clk_k);
        div_code = 4'd3;
        master_sel = 1'b0;
        repeat (5) @(negedge clk_k);
        meas(0, 2 * CLK_PERIOD, CLK_PERIOD, "R8 code change ignored mclk");

        // R9: enable low silences everything; re-enable resumes
        @(negedge clk_k);
        run_en = 1'b0;
        @(negedge clk_k);
        watch_low(40, 1, 1, "R9 disabled");
        configure(1, 1, 0, 4'd2);
        meas(0, 4 * CLK_PERIOD, 2 * CLK_PERIOD, "R9 resume mclk");

        // R5: slave mode, pass-through code (gate leak would show)
        configure(0, 1, 0, 4'd0);
        watch_low(600, 1, 1, "R5 slave");
        configure(0, 1, 0, 4'd1);
        watch_low(600, 1, 1, "R5 slave divided");

        // R6: no-divide override
        configure(1, 1, 1, 4'd0);
        watch_low(200, 1, 0, "R6 nodiv pass-through");
        configure(1, 1, 1, 4'd1);
        watch_low(200, 1, 0, "R6 nodiv divided");
        meas(1, 8 * CLK_PERIOD, 4 * CLK_PERIOD, "R6 bclk under nodiv");
        expect_frames(1, 512);

        // R7: non-TDM protocol
        configure(1, 0, 0, 4'd0);
        watch_low(200, 1, 0, "R7 non-tdm pass-through");
        configure(1, 0, 0, 4'd2);
        watch_low(200, 1, 0, "R7 non-tdm divided");
        meas(1, 16 * CLK_PERIOD, 8 * CLK_PERIOD, "R7 bclk under non-tdm");

        @(negedge clk_k);
        run_en = 1'b0;
        repeat (4) @(negedge clk_k);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule